// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block keeps the replacement state for an eight-way set-associative cache with 128 sets. Each set has one presence bit per way and a seven-bit binary decision tree. The tree approximates least-recent use. Tags, data arrays and bus traffic live elsewhere. The cache controller uses this block in three ways:

- It reports every hit or line fill on the access port. The tree of that set then points away from the touched way.
- It asks for a replacement way for any set on the victim port. The answer comes back in the same cycle.
- It can drop single lines, or clear every set at once.

Victim choice has two sources:

- **Empty ways first.** A way whose presence bit is clear wins over the tree, and the lowest-numbered empty way is taken.
- **Flush-assist mode.** When this mode is on, the empty-way preference is switched off and the tree alone decides. Software can then walk every way of a set with a fixed number of refills.

Top module: `plru_repl_sel`

## Requirements
- R1: After reset every set has all ways empty and all tree bits zero. The victim for any set is therefore way 0.
- R2: When flush-assist is off and the addressed set has at least one empty way, the victim is the lowest-numbered empty way.
- R3: When every way is present, or when flush-assist is on, the victim comes from tree bits T0..T6:
  - T0=0 goes to T1. T1=0 then gives way 0 or way 1 by T3. T1=1 gives way 2 or way 3 by T4.
  - T0=1 goes to T2. T2=0 gives way 4 or way 5 by T5. T2=1 gives way 6 or way 7 by T6.
  - In each leaf pair, a zero picks the even way and a one picks the odd way.
- R4: An access to way w changes only the three tree bits on the path to w. Each of them points away from w.
  - Ways 0 to 3 set T0=1. Ways 4 to 7 set T0=0.
  - The level-two bit (T1 for ways 0 to 3, T2 for ways 4 to 7) is 1 when w mod 4 is below 2, and 0 otherwise.
  - The leaf bit (T3, T4, T5 or T6) is 1 for an even w and 0 for an odd w.
- R5: A fill (access with the fill flag) applies the R4 tree update and marks that way present.
- R6: An invalidate clears one way's presence bit and leaves the tree unchanged. A fill to the same set and way in the same cycle wins, so the way stays present.
- R7: Flash invalidate clears every presence bit and every tree bit of every set in one cycle. It overrides any access or invalidate in the same cycle.
- R8: While flush-assist is on, empty ways are ignored and the victim follows the tree alone.
- R9: The victim is combinational from the registered state of the set on the victim port. Updates become visible after the next clock edge, and an update touches only its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Hit or fill access strobe |
| acc_fill | input | 1 | Access is a fill and marks the way present |
| acc_set | input | 7 | Set index of the access |
| acc_way | input | 3 | Way touched by the access |
| inv_en | input | 1 | Single-way invalidate strobe |
| inv_set | input | 7 | Set index of the invalidate |
| inv_way | input | 3 | Way to invalidate |
| flash_inv | input | 1 | Clear all sets at once |
| flush_assist | input | 1 | Ignore empty ways when choosing a victim |
| vic_set | input | 7 | Set whose victim is requested |
| vic_way | output | 3 | Chosen replacement way |

## Verification
The selector is tried with several input patterns:

- **In-order fills of one set.** These show the empty-way preference stepping upward.
- **Hit sequences on a full set.** These show that each tree update pushes the victim into the opposite subtree, while bits off the path stay untouched.
- **Invalidates followed by victim requests, with and without flush-assist.** These separate the empty-way path from the tree path.
- **Same-cycle collisions.** Fill against invalidate, and flash against fill, pin down the stated priorities.
- **Accesses to one set while another set is watched.** These show that sets are independent.
- **A long random mix over a few sets, compared every cycle against a behavioural model.** This catches wrong bit positions in the walk or the update.

// File: rtl/plru_pkg.sv
package plru_pkg;

    // Kind of state update requested by the access port in one cycle.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_HIT  = 2'd1,
        UPD_FILL = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/plru_tree_next.sv
// Next tree value after touching one way: every node on the path is
// turned to point at the other half of its subtree.
module plru_tree_next #(
    parameter  int WAYS  = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] tree_i,
    input  logic [WAY_W-1:0] way_i,
    output logic [NODES-1:0] tree_o
);
    always_comb begin
        int node;
        logic dir;
        tree_o = tree_i;
        node   = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            dir          = way_i[WAY_W-1-lvl];
            tree_o[node] = ~dir;
            node         = 2 * node + 1 + int'(dir);
        end
    end
endmodule

// File: rtl/plru_tree_walk.sv
// Follows the tree from the root; each node bit picks the half to descend.
module plru_tree_walk #(
    parameter  int WAYS  = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] tree_i,
    output logic [WAY_W-1:0] way_o
);
    always_comb begin
        int node;
        logic dir;
        way_o = '0;
        node  = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            dir                  = tree_i[node];
            way_o[WAY_W-1-lvl]   = dir;
            node                 = 2 * node + 1 + int'(dir);
        end
    end
endmodule

// File: rtl/plru_first_free.sv
// Lowest-numbered way whose presence bit is clear.
module plru_first_free #(
    parameter  int WAYS  = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld_i,
    output logic             any_free_o,
    output logic [WAY_W-1:0] free_way_o
);
    always_comb begin
        any_free_o = 1'b0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) begin
                any_free_o = 1'b1;
                free_way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/plru_repl_sel.sv
module plru_repl_sel
    import plru_pkg::*;
#(
    parameter  int NUM_SETS = 128,
    parameter  int WAYS     = 8,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld,
    input  logic             acc_fill,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    input  logic             flash_inv,
    input  logic             flush_assist,
    input  logic [SET_W-1:0] vic_set,
    output logic [WAY_W-1:0] vic_way
);
    localparam int NODES = WAYS - 1;

    typedef struct packed {
        logic [WAYS-1:0]  vld;
        logic [NODES-1:0] tree;
    } set_st_t;

    set_st_t st_q [NUM_SETS];
    set_st_t st_d [NUM_SETS];

    upd_kind_e        upd_kind;
    logic [NODES-1:0] acc_tree_nxt;
    logic [WAYS-1:0]  vic_vld_vec;
    logic [NODES-1:0] vic_tree_vec;
    logic             vic_any_free;
    logic [WAY_W-1:0] vic_free_way;
    logic [WAY_W-1:0] vic_tree_way;

    // ---------------- update path ----------------
    assign upd_kind = !acc_vld ? UPD_NONE : (acc_fill ? UPD_FILL : UPD_HIT);

    plru_tree_next #(.WAYS(WAYS)) u_tree_next (
        .tree_i (st_q[acc_set].tree),
        .way_i  (acc_way),
        .tree_o (acc_tree_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (flash_inv) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                st_d[s] = '0;
            end
        end else begin
            if (inv_en) begin
                st_d[inv_set].vld[inv_way] = 1'b0;
            end
            case (upd_kind)
                UPD_HIT: begin
                    st_d[acc_set].tree = acc_tree_nxt;
                end
                UPD_FILL: begin
                    st_d[acc_set].tree         = acc_tree_nxt;
                    st_d[acc_set].vld[acc_way] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                st_q[s] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- victim path ----------------
    assign vic_vld_vec  = st_q[vic_set].vld;
    assign vic_tree_vec = st_q[vic_set].tree;

    plru_first_free #(.WAYS(WAYS)) u_first_free (
        .vld_i      (vic_vld_vec),
        .any_free_o (vic_any_free),
        .free_way_o (vic_free_way)
    );

    plru_tree_walk #(.WAYS(WAYS)) u_tree_walk (
        .tree_i (vic_tree_vec),
        .way_o  (vic_tree_way)
    );

    assign vic_way = (vic_any_free && !flush_assist) ? vic_free_way : vic_tree_way;

endmodule

// File: rtl/plru_repl_sel_chk.sv
module plru_repl_sel_chk #(
    parameter  int NUM_SETS = 128,
    parameter  int WAYS     = 8,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_vld,
    input logic             acc_fill,
    input logic [SET_W-1:0] acc_set,
    input logic [WAY_W-1:0] acc_way,
    input logic             inv_en,
    input logic [SET_W-1:0] inv_set,
    input logic [WAY_W-1:0] inv_way,
    input logic             flash_inv,
    input logic             flush_assist,
    input logic [SET_W-1:0] vic_set,
    input logic [WAY_W-1:0] vic_way,
    input logic [WAYS-1:0]  vic_vld_vec
);
    logic            seen_q;
    logic [WAYS-1:0] low_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign low_mask = (WAYS'(1) << vic_way) - WAYS'(1);

    // R7: a flash invalidate leaves every set pointing at way 0
    a_r7_flash_to_way0: assert property (@(posedge clk) disable iff (!rst_n)
        flash_inv |=> (vic_way == '0));

    // R2: the chosen empty way is empty and all lower ways are present
    a_r2_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_assist && !(&vic_vld_vec)) |->
            (!vic_vld_vec[vic_way] && ((vic_vld_vec & low_mask) == low_mask)));

    // R5: right after a fill the same set never offers the filled way
    a_r5_fill_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(acc_vld && acc_fill && !flash_inv) && (vic_set == $past(acc_set)))
            |-> (vic_way != $past(acc_way)));

    // R6: after invalidating a way, the victim of that set is at or below it
    a_r6_invalidate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(inv_en && !flash_inv && !(acc_vld && acc_set == inv_set))
            && (vic_set == $past(inv_set)) && !flush_assist)
            |-> (vic_way <= $past(inv_way)));

    // R9: with no update and unchanged request, the answer holds
    a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(!acc_vld && !inv_en && !flash_inv)
            && $stable(vic_set) && $stable(flush_assist)) |-> $stable(vic_way));

endmodule

bind plru_repl_sel plru_repl_sel_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_vld      (acc_vld),
    .acc_fill     (acc_fill),
    .acc_set      (acc_set),
    .acc_way      (acc_way),
    .inv_en       (inv_en),
    .inv_set      (inv_set),
    .inv_way      (inv_way),
    .flash_inv    (flash_inv),
    .flush_assist (flush_assist),
    .vic_set      (vic_set),
    .vic_way      (vic_way),
    .vic_vld_vec  (vic_vld_vec)
);

// File: tb/plru_repl_sel_tb.sv
`timescale 1ns/1ps
module plru_repl_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_vld, acc_fill, inv_en, flash_inv, flush_assist;
    logic [6:0] acc_set, inv_set, vic_set;
    logic [2:0] acc_way, inv_way;
    logic [2:0] vic_way;

    int checks = 0;
    int errors = 0;

    bit mv [0:127][0:7];
    bit mt [0:127][0:6];

    always #2.5 clk = ~clk;

    plru_repl_sel u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_vld(acc_vld), .acc_fill(acc_fill), .acc_set(acc_set), .acc_way(acc_way),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .flash_inv(flash_inv), .flush_assist(flush_assist),
        .vic_set(vic_set), .vic_way(vic_way)
    );

    function automatic int mvict(int s, bit fa);
        if (!fa) for (int w = 0; w < 8; w++) if (!mv[s][w]) return w;
        if (mt[s][0] == 1'b0) begin
            if (mt[s][1] == 1'b0) return mt[s][3] ? 1 : 0;
            else                  return mt[s][4] ? 3 : 2;
        end else begin
            if (mt[s][2] == 1'b0) return mt[s][5] ? 5 : 4;
            else                  return mt[s][6] ? 7 : 6;
        end
    endfunction

    task automatic mtouch(int s, int w);
        case (w)
            0: begin mt[s][0] = 1; mt[s][1] = 1; mt[s][3] = 1; end
            1: begin mt[s][0] = 1; mt[s][1] = 1; mt[s][3] = 0; end
            2: begin mt[s][0] = 1; mt[s][1] = 0; mt[s][4] = 1; end
            3: begin mt[s][0] = 1; mt[s][1] = 0; mt[s][4] = 0; end
            4: begin mt[s][0] = 0; mt[s][2] = 1; mt[s][5] = 1; end
            5: begin mt[s][0] = 0; mt[s][2] = 1; mt[s][5] = 0; end
            6: begin mt[s][0] = 0; mt[s][2] = 0; mt[s][6] = 1; end
            default: begin mt[s][0] = 0; mt[s][2] = 0; mt[s][6] = 0; end
        endcase
    endtask

    task automatic mclear();
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 8; w++) mv[s][w] = 0;
            for (int b = 0; b < 7; b++) mt[s][b] = 0;
        end
    endtask

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: vic_way actual %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(bit av, bit af, int aset, int away, bit ie, int iset, int iway,
                        bit fl, bit fa, int vset, string req);
        @(negedge clk);
        acc_vld = av; acc_fill = af; acc_set = 7'(aset); acc_way = 3'(away);
        inv_en = ie; inv_set = 7'(iset); inv_way = 3'(iway);
        flash_inv = fl; flush_assist = fa; vic_set = 7'(vset);
        #1;
        check(req, int'(vic_way), mvict(vset, fa));
        @(posedge clk);
        if (fl) mclear();
        else begin
            if (ie) mv[iset][iway] = 0;
            if (av) begin
                mtouch(aset, away);
                if (af) mv[aset][away] = 1;
            end
        end
    endtask

    task automatic look(int vset, bit fa, string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, fa, vset, req);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mclear();
        rst_n = 0; acc_vld = 0; acc_fill = 0; acc_set = 0; acc_way = 0;
        inv_en = 0; inv_set = 0; inv_way = 0; flash_inv = 0; flush_assist = 0; vic_set = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state, every set empty, victim way 0
        look(0, 0, "R1"); look(64, 0, "R1"); look(127, 0, "R1"); look(5, 1, "R1");

        // R5 / R2: fill set 3 in order; victim climbs through the empty ways
        for (int w = 0; w < 8; w++) step(1, 1, 3, w, 0, 0, 0, 0, 0, 3, "R2");
        look(3, 0, "R5");

        // R3 / R4: hits on the full set
        step(1, 0, 3, 5, 0, 0, 0, 0, 0, 3, "R4");
        look(3, 0, "R4");
        step(1, 0, 3, 2, 0, 0, 0, 0, 0, 3, "R4");
        look(3, 0, "R4");
        step(1, 0, 3, 7, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 0, 3, 0, 0, 0, 0, 0, 0, 3, "R3");
        step(1, 0, 3, 3, 0, 0, 0, 0, 0, 3, "R3");
        look(3, 0, "R3");

        // R6: invalidate clears presence and leaves the tree
        step(0, 0, 0, 0, 1, 3, 6, 0, 0, 3, "R6");
        look(3, 0, "R6");
        look(3, 1, "R8");
        step(0, 0, 0, 0, 1, 3, 2, 0, 0, 3, "R6");
        look(3, 0, "R6");
        step(1, 1, 3, 2, 1, 3, 2, 0, 0, 3, "R6");
        look(3, 0, "R6");

        // R8: flush-assist ignores the empty way 6
        look(3, 1, "R8");
        step(1, 0, 3, 4, 0, 0, 0, 0, 1, 3, "R8");
        look(3, 1, "R8");

        // R9: updates to set 9 do not disturb set 3
        step(1, 1, 9, 0, 0, 0, 0, 0, 0, 3, "R9");
        step(1, 1, 9, 1, 0, 0, 0, 0, 0, 3, "R9");
        look(3, 0, "R9");
        look(9, 0, "R9");

        // R7: flash beats a same-cycle fill and invalidate
        step(1, 1, 3, 6, 1, 9, 0, 1, 0, 3, "R7");
        look(3, 0, "R7"); look(9, 0, "R7"); look(3, 1, "R7");

        // Random mix over a few sets
        for (int n = 0; n < 6000; n++) begin
            int sets[4] = '{0, 1, 2, 127};
            int aset, iset, vset, away, iway;
            bit av, af, ie, fl, fa;
            string req;
            aset = sets[$urandom_range(0, 3)];
            iset = sets[$urandom_range(0, 3)];
            vset = sets[$urandom_range(0, 3)];
            away = $urandom_range(0, 7);
            iway = $urandom_range(0, 7);
            av   = ($urandom_range(0, 3) != 0);
            af   = ($urandom_range(0, 2) == 0);
            ie   = ($urandom_range(0, 9) == 0);
            fl   = ($urandom_range(0, 499) == 0);
            fa   = ($urandom_range(0, 4) == 0);
            if (fa) req = "R8";
            else begin
                req = "R3";
                for (int w = 0; w < 8; w++) if (!mv[vset][w]) req = "R2";
            end
            step(av, af, aset, away, ie, iset, iway, fl, fa, vset, req);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule